// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block guards the write path of a peripheral register file. Every write on a simple single-cycle register bus passes through it. A write to an ordinary register address reaches the register file only while the gate is open. Two kick registers live at fixed addresses, and software opens the gate by writing them in order. Kick A must receive its 32-bit key first, and kick B must then receive its own key. A zero or any other wrong value written to either kick register shuts the gate again.

Reads never pass through the block, so software can read protected registers at any time without unlocking. A write to a protected address while the gate is shut is dropped without any response on the bus. The write also sets a sticky violation flag, which only a reset clears. Writes to the kick registers are always accepted. They change only the state of the gate and never reach the register file.

Top module: `kick_write_lock`

## Requirements
- R1: After reset the gate is shut (`unlocked` = 0), `violation` is 0, and `prot_we` is 0 while no write is presented. A reset while the gate is open shuts it and clears `violation`.
- R2: While `unlocked` is 1, a write to any address other than the two kick addresses raises `prot_we` in the same cycle as `wr_en`.
- R3: While `unlocked` is 0, a write to a non-kick address leaves `prot_we` at 0. From the next cycle `violation` is 1 and stays 1 until reset.
- R4: A write of 0x83E70B13 to kick A (address 0x6C) followed by a write of 0x95A4F1E0 to kick B (address 0x70) opens the gate. `unlocked` rises in the cycle after the kick B write.
- R5: The kick B key written without a preceding kick A key leaves the gate shut.
- R6: Any value other than its key written to kick A or kick B shuts the gate and discards a pending kick A key, so a later kick B key alone does not open the gate.
- R7: Writing zero to either kick register shuts an open gate from the next cycle.
- R8: Writes to kick A or kick B never raise `prot_we` and never set `violation`, in any gate state.
- R9: A write to a non-kick address between the kick A key and the kick B key is dropped but does not cancel the pending kick A key.
- R10: Writing the kick A key while the gate is open shuts the gate until the kick B key follows.
- R11: Without a write to a kick register, `unlocked` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| prot_we | output | 1 | Gated write enable to the protected register file |
| unlocked | output | 1 | Gate is open |
| violation | output | 1 | Sticky flag: a protected write was dropped |

## Verification
`prot_we` is combinational, so its value is due in the same cycle as the strobe. The bench samples it after the inputs settle and before the rising edge that ends the write. `unlocked` and `violation` are registered and change at the edge that ends the write, so the bench samples them one time unit after that edge. Each vector in the table therefore drives once and makes all three checks inside its own cycle. This keeps state-dependent sequences aligned: a pending kick A key, its loss after a wrong value, and the re-shut caused by a second kick A key.

// File: rtl/kick_lock_pkg.sv
package kick_lock_pkg;

    localparam int LK_ADDR_W = 8;
    localparam int LK_DATA_W = 32;

    localparam logic [LK_ADDR_W-1:0] LK_KICK_A_ADDR = 8'h6C;
    localparam logic [LK_ADDR_W-1:0] LK_KICK_B_ADDR = 8'h70;

    localparam logic [LK_DATA_W-1:0] LK_KEY_A = 32'h83E7_0B13;
    localparam logic [LK_DATA_W-1:0] LK_KEY_B = 32'h95A4_F1E0;

    typedef enum logic [1:0] {
        GATE_SHUT  = 2'd0,
        GATE_ARMED = 2'd1,
        GATE_OPEN  = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic kick_a;
        logic kick_b;
        logic prot;
    } wr_class_t;

    function automatic gate_state_e gate_next(
        input gate_state_e cur,
        input wr_class_t   cls,
        input logic        key_a_ok,
        input logic        key_b_ok
    );
        gate_state_e nxt;
        nxt = cur;
        if (cls.kick_a) begin
            nxt = key_a_ok ? GATE_ARMED : GATE_SHUT;
        end else if (cls.kick_b) begin
            if (!key_b_ok) begin
                nxt = GATE_SHUT;
            end else if (cur == GATE_ARMED) begin
                nxt = GATE_OPEN;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/kick_lock_decode.sv
module kick_lock_decode
    import kick_lock_pkg::*;
#(
    parameter int ADDR_W = LK_ADDR_W,
    parameter logic [ADDR_W-1:0] KICK_A = LK_KICK_A_ADDR,
    parameter logic [ADDR_W-1:0] KICK_B = LK_KICK_B_ADDR
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_class_t         cls
);

    logic hit_a;
    logic hit_b;

    assign hit_a = (wr_addr == KICK_A);
    assign hit_b = (wr_addr == KICK_B);

    always_comb begin
        cls.kick_a = wr_en && hit_a;
        cls.kick_b = wr_en && hit_b;
        cls.prot   = wr_en && !hit_a && !hit_b;
    end

endmodule

// File: rtl/kick_lock_seq.sv
module kick_lock_seq
    import kick_lock_pkg::*;
#(
    parameter int DATA_W = LK_DATA_W,
    parameter logic [DATA_W-1:0] KEY_A = LK_KEY_A,
    parameter logic [DATA_W-1:0] KEY_B = LK_KEY_B
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_class_t         cls,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked_o
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        key_a_ok;
    logic        key_b_ok;

    assign key_a_ok = (wr_data == KEY_A);
    assign key_b_ok = (wr_data == KEY_B);

    always_comb begin
        state_d = gate_next(state_q, cls, key_a_ok, key_b_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_SHUT;
        end else begin
            state_q <= state_d;
        end
    end

    assign unlocked_o = (state_q == GATE_OPEN);

    // R4
    open_needs_key_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked_o) |-> $past(cls.kick_b && key_b_ok));

    // R6
    bad_key_shuts_chk: assert property (@(posedge clk) disable iff (rst)
        ((cls.kick_a && !key_a_ok) || (cls.kick_b && !key_b_ok)) |=> !unlocked_o);

    // R5
    lone_key_b_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_SHUT && cls.kick_b) |=> !unlocked_o);

    // R11
    hold_without_kick_chk: assert property (@(posedge clk) disable iff (rst)
        (!cls.kick_a && !cls.kick_b) |=> $stable(state_q));

endmodule

// File: rtl/kick_lock_gate.sv
module kick_lock_gate
    import kick_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_class_t cls,
    input  logic      unlocked_i,
    output logic      prot_we_o,
    output logic      violation_o
);

    logic drop;

    assign prot_we_o = cls.prot && unlocked_i;
    assign drop      = cls.prot && !unlocked_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            violation_o <= 1'b0;
        end else if (drop) begin
            violation_o <= 1'b1;
        end
    end

    // R3
    drop_flags_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> violation_o);

    // R3
    violation_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        violation_o |=> violation_o);

endmodule

// File: rtl/kick_write_lock.sv
module kick_write_lock
    import kick_lock_pkg::*;
#(
    parameter int ADDR_W = LK_ADDR_W,
    parameter int DATA_W = LK_DATA_W,
    parameter logic [ADDR_W-1:0] KICK_A = LK_KICK_A_ADDR,
    parameter logic [ADDR_W-1:0] KICK_B = LK_KICK_B_ADDR,
    parameter logic [DATA_W-1:0] KEY_A  = LK_KEY_A,
    parameter logic [DATA_W-1:0] KEY_B  = LK_KEY_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_we,
    output logic              unlocked,
    output logic              violation
);

    wr_class_t cls;

    kick_lock_decode #(
        .ADDR_W (ADDR_W),
        .KICK_A (KICK_A),
        .KICK_B (KICK_B)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cls     (cls)
    );

    kick_lock_seq #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cls        (cls),
        .wr_data    (wr_data),
        .unlocked_o (unlocked)
    );

    kick_lock_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .cls         (cls),
        .unlocked_i  (unlocked),
        .prot_we_o   (prot_we),
        .violation_o (violation)
    );

    // R2
    we_only_when_open_chk: assert property (@(posedge clk) disable iff (rst)
        prot_we |-> unlocked);

    // R8
    kick_never_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == KICK_A || wr_addr == KICK_B)) |-> !prot_we);

    // R8
    kick_no_violation_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == KICK_A || wr_addr == KICK_B) && !violation) |=> !violation);

endmodule

// File: tb/kick_write_lock_bench.sv
module kick_write_lock_bench;

    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;

    typedef struct packed {
        logic [3:0]  req;
        logic        en;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        we;
        logic        unl;
        logic        vio;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{4'd8,  1'b1, 8'h6C, KA,           1'b0, 1'b0, 1'b0}, // R8 kick A key
        '{4'd4,  1'b1, 8'h70, KB,           1'b0, 1'b1, 1'b0}, // R4 opens
        '{4'd2,  1'b1, 8'h60, 32'h0000DEAD, 1'b1, 1'b1, 1'b0}, // R2
        '{4'd2,  1'b1, 8'h00, 32'h00001234, 1'b1, 1'b1, 1'b0}, // R2
        '{4'd11, 1'b0, 8'h00, 32'h0,        1'b0, 1'b1, 1'b0}, // R11 idle
        '{4'd7,  1'b1, 8'h70, 32'h0,        1'b0, 1'b0, 1'b0}, // R7 zero
        '{4'd5,  1'b1, 8'h70, KB,           1'b0, 1'b0, 1'b0}, // R5 lone key B
        '{4'd3,  1'b1, 8'h10, 32'h55,       1'b0, 1'b0, 1'b1}, // R3 dropped
        '{4'd6,  1'b1, 8'h6C, KA,           1'b0, 1'b0, 1'b1}, // R6 armed
        '{4'd6,  1'b1, 8'h70, 32'h95A4F1E1, 1'b0, 1'b0, 1'b1}, // R6 wrong B
        '{4'd6,  1'b1, 8'h70, KB,           1'b0, 1'b0, 1'b1}, // R6 progress lost
        '{4'd9,  1'b1, 8'h6C, KA,           1'b0, 1'b0, 1'b1}, // R9 armed
        '{4'd9,  1'b1, 8'h20, 32'h77,       1'b0, 1'b0, 1'b1}, // R9 dropped
        '{4'd9,  1'b1, 8'h70, KB,           1'b0, 1'b1, 1'b1}, // R9 still opens
        '{4'd10, 1'b1, 8'h6C, KA,           1'b0, 1'b0, 1'b1}, // R10 re-arm shuts
        '{4'd10, 1'b1, 8'h24, 32'h99,       1'b0, 1'b0, 1'b1}, // R10 blocked
        '{4'd10, 1'b1, 8'h70, KB,           1'b0, 1'b1, 1'b1}, // R10 reopens
        '{4'd6,  1'b1, 8'h6C, 32'h1,        1'b0, 1'b0, 1'b1}, // R6 wrong A
        '{4'd4,  1'b1, 8'h6C, KA,           1'b0, 1'b0, 1'b1}, // R4
        '{4'd4,  1'b1, 8'h70, KB,           1'b0, 1'b1, 1'b1}, // R4
        '{4'd7,  1'b1, 8'h6C, 32'h0,        1'b0, 1'b0, 1'b1}  // R7 zero A
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        prot_we;
    logic        unlocked;
    logic        violation;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    kick_write_lock u_kick_write_lock (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prot_we   (prot_we),
        .unlocked  (unlocked),
        .violation (violation)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic en, input logic [7:0] a, input logic [31:0] d,
                        input logic exp_we, input logic exp_unl, input logic exp_vio);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        #2;
        chk(tag, "prot_we", prot_we, exp_we);
        @(posedge clk);
        #1;
        chk(tag, "unlocked", unlocked, exp_unl);
        chk(tag, "violation", violation, exp_vio);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        chk("R1", "unlocked", unlocked, 1'b0);
        chk("R1", "violation", violation, 1'b0);
        chk("R1", "prot_we", prot_we, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].en, VEC[i].addr, VEC[i].data,
                 VEC[i].we, VEC[i].unl, VEC[i].vio);
        end

        // R8 kick writes while open do not pass or flag
        step("R8", 1'b1, 8'h6C, KA, 1'b0, 1'b0, 1'b1);
        step("R8", 1'b1, 8'h70, KB, 1'b0, 1'b1, 1'b1);
        step("R8", 1'b1, 8'h70, KB, 1'b0, 1'b1, 1'b1);

        // R1 reset while open shuts and clears violation
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1", "unlocked", unlocked, 1'b0);
        chk("R1", "violation", violation, 1'b0);
        step("R1", 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b0);

        // R3 locked write right after reset
        step("R3", 1'b1, 8'h68, 32'hABCD, 1'b0, 1'b0, 1'b1);
        step("R3", 1'b0, 8'h00, 32'h0, 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        finish_run();
    end

endmodule